// File: doc/BRIEF.md
# Biphase-Mark Serial Audio Subframe Encoder

This block turns a stream of 16-bit stereo PCM samples into the line-coded serial output of a consumer digital audio link in the IEC 60958 style. Each sample fills one 32-slot subframe. The subframe holds a synchronisation preamble, an auxiliary field, a 20-slot audio field, and four trailing flag slots. Every slot after the preamble is biphase-mark coded into two line cells, so a subframe is 64 cells and a stereo frame is 128 cells. The block emits one cell each time `cell_en` is high. The surrounding logic supplies that enable at 128 times the sample rate.

Samples arrive on a valid/ready handshake. The channels alternate: subframes with an even index carry the first channel and odd ones carry the second. The block counts subframes modulo 384, which is 192 frames, and marks the first subframe of each block with a distinct preamble. A `mute` input, sampled together with each sample, raises the validity flag so that receivers silence that sample. If no sample is offered at a subframe boundary, the block sends a zero sample flagged invalid. One auxiliary slot is chosen so that the parity over the coded part of each subframe is even. As a result the parity slot is always zero and the line level returns to its starting value by the end of every subframe.

The controller is a three-state machine. The states are `ST_IDLE` (line held low, waiting for the first sample), `ST_PREAMBLE` (cells 0 to 7, sent as a raw pattern) and `ST_PAYLOAD` (cells 8 to 63, biphase-mark coded). The transitions are: `ST_IDLE` to `ST_PREAMBLE` when the first sample is accepted; `ST_PREAMBLE` to `ST_PAYLOAD` on the enabled cycle of cell 7; `ST_PAYLOAD` to `ST_PREAMBLE` on the enabled cycle of cell 63. There is no way back to `ST_IDLE` except reset.

Top module: `spdif_bmc_encoder`

## Requirements
- R1: From reset until the first sample is accepted, `line_out` is 0 and `smp_ready` is 1. Encoding then starts at subframe index 0.
- R2: `line_out` changes only on the clock edge that follows a cycle with `cell_en` high. Each such edge emits the next cell, and cycles with `cell_en` low leave the line unchanged.
- R3: A subframe is 64 cells, which is 32 slots of 2 cells each. Slots 0-3 are the preamble. Slots 4-7 are auxiliary bits, with slot 4 being aux bit 0. Slots 8-11 are zero padding. Slots 12-27 carry the sample, least significant bit first. Slots 28, 29, 30 and 31 are the validity, user, status and parity flags.
- R4: Every coded slot (4-31) starts with a line toggle in its first cell. Its second cell toggles again if and only if the slot bit is 1.
- R5: Preambles are 8 raw cells, sent first bit first. Subframe index 0 sends 11101000. Other even indices send 11100010, and odd indices send 11100100.
- R6: The preamble pattern is XORed with the line level that ended the previous subframe. Because of R7, that level is always 0, so the last cell of every subframe equals the level before its preamble.
- R7: Aux bit 0 is the XOR of the 16 sample bits and the validity flag. The other aux bits and the user, status and parity flags are 0.
- R8: The subframe index counts 0 to 383 and wraps, so subframe 384 sends the block-start preamble again.
- R9: While running, `smp_ready` is 1 only in a cycle where `cell_en` is high during the last cell (63) of a subframe. A sample is taken on a clock edge where `smp_valid` and `smp_ready` are both 1.
- R10: If `mute` is 1 when a sample is taken, that subframe sends validity flag 1 and still carries the sample bits.
- R11: If `smp_valid` is 0 at a running subframe boundary, the next subframe carries a zero sample with validity flag 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cell_en | input | 1 | Emit one line cell this cycle |
| smp_valid | input | 1 | Sample offered |
| smp_ready | output | 1 | Sample taken on this edge if offered |
| smp_data | input | 16 | PCM sample, two's complement |
| mute | input | 1 | Flag the offered sample as invalid |
| line_out | output | 1 | Serial line-coded output |

## Verification
The assertions assume that `cell_en` and the sample inputs change only between clock edges. They also assume that `smp_data` and `mute` are meaningful whenever `smp_valid` is high. The level-return check further assumes that reset is applied before the first sample. The stimulus drives every input on the falling edge and holds each offered sample for a whole subframe, so a sample is only ever taken at a cell-63 boundary. The stimulus also pauses `cell_en` in the middle of a subframe, so the hold property is exercised while the line is high as well as while it is low.

// File: rtl/spdif_enc_pkg.sv
package spdif_enc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_PREAMBLE = 2'd1,
        ST_PAYLOAD  = 2'd2
    } enc_state_e;

    // Raw preamble cells, transmitted from bit 7 down to bit 0.
    localparam logic [7:0] PRE_BLOCK_START = 8'b1110_1000;
    localparam logic [7:0] PRE_FIRST_CHAN  = 8'b1110_0010;
    localparam logic [7:0] PRE_SECOND_CHAN = 8'b1110_0100;

    localparam int SLOTS_PER_SUBFRAME = 32;
    localparam int CELLS_PER_SLOT     = 2;
    localparam int PREAMBLE_SLOTS     = 4;
    localparam int FLAG_SLOTS         = 4;

endpackage

// File: rtl/spdif_subframe_ctr.sv
module spdif_subframe_ctr #(
    parameter  int FRAMES_PER_BLOCK = 192,
    localparam int SUBFRAMES        = 2 * FRAMES_PER_BLOCK,
    localparam int IDX_W            = $clog2(SUBFRAMES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [IDX_W-1:0] sf_idx,
    output logic             block_start,
    output logic             second_chan
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SUBFRAMES - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sf_idx <= '0;
        end else if (advance) begin
            sf_idx <= (sf_idx == LAST_IDX) ? '0 : sf_idx + 1'b1;
        end
    end

    assign block_start = (sf_idx == '0);
    assign second_chan = sf_idx[0];

    // R8: the index never leaves the block range
    a_r8_index_range: assert property (@(posedge clk) disable iff (!rst_n)
        sf_idx <= LAST_IDX);

    // R8: advancing from the last subframe returns to the block start
    a_r8_block_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && sf_idx == LAST_IDX) |=> block_start);

endmodule

// File: rtl/spdif_payload_pack.sv
module spdif_payload_pack #(
    parameter  int SAMPLE_W  = 16,
    parameter  int AUDIO_W   = 20,
    parameter  int AUX_W     = 4,
    localparam int PAD_W     = AUDIO_W - SAMPLE_W,
    localparam int PAYLOAD_W = AUX_W + AUDIO_W + spdif_enc_pkg::FLAG_SLOTS
) (
    input  logic [SAMPLE_W-1:0]  sample,
    input  logic                 invalid,
    output logic [PAYLOAD_W-1:0] payload
);

    logic [AUDIO_W-1:0] audio;
    logic               par_fix;

    generate
        if (PAD_W > 0) begin : g_pad
            assign audio = {sample, {PAD_W{1'b0}}};
        end else begin : g_nopad
            assign audio = sample;
        end
    endgenerate

    // Aux bit 0 makes the coded slots even: user, status and parity stay 0.
    assign par_fix = (^sample) ^ invalid;

    // Index order is slot order: aux first, flags last {P,C,U,V}.
    assign payload = {3'b000, invalid, audio, {(AUX_W-1){1'b0}}, par_fix};

endmodule

// File: rtl/spdif_bmc_encoder.sv
module spdif_bmc_encoder
    import spdif_enc_pkg::*;
#(
    parameter  int SAMPLE_W         = 16,
    parameter  int AUDIO_W          = 20,
    parameter  int AUX_W            = 4,
    parameter  int FRAMES_PER_BLOCK = 192,
    localparam int CELLS      = SLOTS_PER_SUBFRAME * CELLS_PER_SLOT,
    localparam int CELL_W     = $clog2(CELLS),
    localparam int SLOT_W     = CELL_W - 1,
    localparam int PRE_CELLS  = PREAMBLE_SLOTS * CELLS_PER_SLOT,
    localparam int PRE_W      = $clog2(PRE_CELLS),
    localparam int PAYLOAD_W  = AUX_W + AUDIO_W + FLAG_SLOTS,
    localparam int IDX_W      = $clog2(2 * FRAMES_PER_BLOCK)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cell_en,
    input  logic                smp_valid,
    output logic                smp_ready,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic                mute,
    output logic                line_out
);

    localparam logic [CELL_W-1:0] LAST_CELL = CELL_W'(CELLS - 1);
    localparam logic [CELL_W-1:0] PRE_LAST  = CELL_W'(PRE_CELLS - 1);

    enc_state_e            state_q, state_d;
    logic [CELL_W-1:0]     cell_idx;
    logic [SAMPLE_W-1:0]   data_q;
    logic                  inval_q;
    logic                  pol_q;
    logic                  line_q;

    logic                  accept;
    logic                  sf_end;
    logic                  pol_now;
    logic [7:0]            pre_pat;
    logic [PRE_W-1:0]      pre_pos;
    logic [SLOT_W-1:0]     pay_slot;
    logic [PAYLOAD_W-1:0]  payload;
    logic [SLOTS_PER_SUBFRAME-1:0] pay_ext;
    logic                  next_cell;
    logic [IDX_W-1:0]      sf_idx;
    logic                  block_start;
    logic                  second_chan;

    // ---------------- handshake and boundary -------------------------
    assign sf_end    = cell_en && (state_q == ST_PAYLOAD) && (cell_idx == LAST_CELL);
    assign smp_ready = (state_q == ST_IDLE) || sf_end;
    assign accept    = smp_valid && smp_ready;

    spdif_subframe_ctr #(
        .FRAMES_PER_BLOCK (FRAMES_PER_BLOCK)
    ) u_ctr (
        .clk         (clk),
        .rst_n       (rst_n),
        .advance     (sf_end),
        .sf_idx      (sf_idx),
        .block_start (block_start),
        .second_chan (second_chan)
    );

    spdif_payload_pack #(
        .SAMPLE_W (SAMPLE_W),
        .AUDIO_W  (AUDIO_W),
        .AUX_W    (AUX_W)
    ) u_pack (
        .sample  (data_q),
        .invalid (inval_q),
        .payload (payload)
    );

    // ---------------- state register ---------------------------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (accept) state_d = ST_PREAMBLE;
            ST_PREAMBLE: if (cell_en && cell_idx == PRE_LAST) state_d = ST_PAYLOAD;
            ST_PAYLOAD:  if (sf_end) state_d = ST_PREAMBLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- cell generation --------------------------------
    assign pre_pat  = block_start ? PRE_BLOCK_START :
                      (second_chan ? PRE_SECOND_CHAN : PRE_FIRST_CHAN);
    assign pol_now  = (cell_idx == '0) ? line_q : pol_q;
    assign pre_pos  = PRE_W'(PRE_CELLS - 1) - cell_idx[PRE_W-1:0];
    assign pay_slot = cell_idx[CELL_W-1:1] - SLOT_W'(PREAMBLE_SLOTS);
    assign pay_ext  = {{PREAMBLE_SLOTS{1'b0}}, payload};

    always_comb begin
        next_cell = line_q;
        unique case (state_q)
            ST_PREAMBLE: next_cell = pre_pat[pre_pos] ^ pol_now;
            ST_PAYLOAD:  next_cell = cell_idx[0] ? (line_q ^ pay_ext[pay_slot]) : ~line_q;
            default:     next_cell = 1'b0;
        endcase
    end

    // ---------------- output process ---------------------------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cell_idx <= '0;
            data_q   <= '0;
            inval_q  <= 1'b0;
            pol_q    <= 1'b0;
            line_q   <= 1'b0;
        end else begin
            if (cell_en && state_q != ST_IDLE) begin
                line_q   <= next_cell;
                cell_idx <= (cell_idx == LAST_CELL) ? '0 : cell_idx + 1'b1;
                if (state_q == ST_PREAMBLE && cell_idx == '0) pol_q <= line_q;
            end
            if (accept) begin
                data_q  <= smp_data;
                inval_q <= mute;
            end else if (sf_end) begin
                data_q  <= '0;
                inval_q <= 1'b1;
            end
        end
    end

    assign line_out = line_q;

    // ---------------- assertions -------------------------------------
    // R1: line is low while waiting for the first sample
    a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !line_out);

    // R2: no enable, no line change
    a_r2_hold_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !cell_en |=> $stable(line_out));

    // R4: each coded slot opens with a transition
    a_r4_slot_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_en && state_q == ST_PAYLOAD && !cell_idx[0]) |=> (line_out != $past(line_out)));

    // R6: the line ends each subframe at the level it started from
    a_r6_level_return: assert property (@(posedge clk) disable iff (!rst_n)
        sf_end |=> (line_out == pol_q));

    // R9: a taken sample always starts a fresh preamble
    a_r9_accept_starts_subframe: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (state_q == ST_PREAMBLE && cell_idx == '0));

endmodule

// File: tb/spdif_bmc_encoder_tb_top.sv
`timescale 1ns/1ps
module spdif_bmc_encoder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cell_en = 1'b0;
    logic        smp_valid = 1'b0;
    logic        smp_ready;
    logic [15:0] smp_data = '0;
    logic        mute = 1'b0;
    logic        line_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench-side model state for the subframe currently on the line
    logic [15:0] cur_data;
    logic        cur_inval;
    int          cur_sf;
    logic        cur_lvl;

    always #2.5 clk = ~clk;

    spdif_bmc_encoder dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cell_en   (cell_en),
        .smp_valid (smp_valid),
        .smp_ready (smp_ready),
        .smp_data  (smp_data),
        .mute      (mute),
        .line_out  (line_out)
    );

    function automatic logic [63:0] model_cells(logic [15:0] d, logic inv, int sf, logic lvl);
        logic [63:0] c;
        logic [27:0] slots;
        logic [7:0]  pat;
        logic        lev;
        slots = '0;
        slots[0] = (^d) ^ inv;              // R7 aux bit 0
        for (int i = 0; i < 16; i++) slots[8 + i] = d[i]; // R3 sample LSB first
        slots[24] = inv;                    // R3 validity
        if (sf % 384 == 0)   pat = 8'b11101000; // R5
        else if (sf % 2 == 0) pat = 8'b11100010;
        else                  pat = 8'b11100100;
        for (int k = 0; k < 8; k++) c[k] = pat[7 - k] ^ lvl; // R6
        lev = c[7];
        for (int s = 0; s < 28; s++) begin  // R4
            c[8 + 2*s]     = ~lev;
            c[8 + 2*s + 1] = ~lev ^ slots[s];
            lev = c[8 + 2*s + 1];
        end
        return c;
    endfunction

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One subframe on the line; offers the next sample throughout it.
    task automatic run_subframe(logic [15:0] nd, bit nv, bit nm, bit gap, string req);
        logic [63:0] got, exp;
        bit rdy_ok, hold_ok;
        logic held;
        rdy_ok = 1'b1;
        hold_ok = 1'b1;
        smp_data  = nd;
        smp_valid = nv;
        mute      = nm;
        for (int c = 0; c < 64; c++) begin
            cell_en = 1'b1;
            #0.1;
            if (smp_ready !== (c == 63)) rdy_ok = 1'b0;
            @(posedge clk);
            @(negedge clk);
            got[c] = line_out;
            if (gap && c == 21) begin
                cell_en = 1'b0;
                held = line_out;
                repeat (3) begin
                    @(negedge clk);
                    if (line_out !== held) hold_ok = 1'b0;
                end
            end
        end
        cell_en = 1'b0;
        exp = model_cells(cur_data, cur_inval, cur_sf, cur_lvl);
        check(got === exp, req, $sformatf("subframe %0d cells", cur_sf), got, exp);
        check(rdy_ok, "R9", "ready only at last cell", 64'(rdy_ok), 64'd1);
        check(got[63] === cur_lvl, "R6", "level return", 64'(got[63]), 64'(cur_lvl));
        if (gap) check(hold_ok, "R2", "hold while cell_en low", 64'(hold_ok), 64'd1);
        cur_data  = nv ? nd : 16'h0000;
        cur_inval = !nv || nm;
        cur_sf    = cur_sf + 1;
        cur_lvl   = got[63];
    endtask

    task automatic test_reset_idle();
        bit ok;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(line_out === 1'b0, "R1", "reset line", 64'(line_out), 64'd0);
        check(smp_ready === 1'b1, "R1", "idle ready", 64'(smp_ready), 64'd1);
        ok = 1'b1;
        cell_en = 1'b1;
        repeat (10) begin
            @(negedge clk);
            if (line_out !== 1'b0 || smp_ready !== 1'b1) ok = 1'b0;
        end
        cell_en = 1'b0;
        check(ok, "R1", "idle without sample stays low", 64'(ok), 64'd1);
    endtask

    task automatic test_first_sample();
        smp_data  = 16'h1234;
        smp_valid = 1'b1;
        mute      = 1'b0;
        @(posedge clk);
        @(negedge clk);
        smp_valid = 1'b0;
        check(line_out === 1'b0, "R1", "line before first cell", 64'(line_out), 64'd0);
        cur_data = 16'h1234; cur_inval = 1'b0; cur_sf = 0; cur_lvl = 1'b0;
    endtask

    task automatic test_patterns();
        run_subframe(16'h0000, 1, 0, 0, "R5");   // sends 0x1234 with block-start preamble
        run_subframe(16'hFFFF, 1, 0, 0, "R3");
        run_subframe(16'hA5C3, 1, 0, 0, "R4");
        run_subframe(16'h8001, 1, 0, 0, "R7");
        run_subframe(16'h7FFE, 1, 0, 0, "R4");
        run_subframe(16'h0001, 1, 0, 0, "R7");
    endtask

    task automatic test_enable_gap();
        run_subframe(16'h5A5A, 1, 0, 1, "R2");
        run_subframe(16'h3C3C, 1, 0, 1, "R2");
    endtask

    task automatic test_mute();
        run_subframe(16'hBEEF, 1, 1, 0, "R10");
        run_subframe(16'h0F0F, 1, 0, 0, "R10");  // muted 0xBEEF goes out here
    endtask

    task automatic test_underrun();
        run_subframe(16'hDEAD, 0, 0, 0, "R11");
        run_subframe(16'h1111, 1, 0, 0, "R11");  // zero invalid sample goes out here
    endtask

    task automatic test_block_wrap();
        logic [63:0] exp;
        while (cur_sf < 384) run_subframe(16'(cur_sf * 16'h0137), 1, 0, 0, "R8");
        exp = model_cells(cur_data, cur_inval, cur_sf, cur_lvl);
        check(exp[7:0] === 8'b00010111, "R8", "model block start at 384", 64'(exp[7:0]), 64'h17);
        run_subframe(16'h2222, 1, 0, 0, "R8");   // subframe 384: block start again
        run_subframe(16'h3333, 1, 0, 0, "R8");
        run_subframe(16'h4444, 1, 0, 0, "R8");
    endtask

    initial begin
        test_reset_idle();
        test_first_sample();
        test_patterns();
        test_enable_gap();
        test_mute();
        test_underrun();
        test_block_wrap();
        smp_valid = 1'b0;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule